// File: doc/BRIEF.md
# Converter Control and Result Formatting Front End

This block sits between a byte-wide register port and an 8-input, 10-bit successive-approximation converter. Software programs one control byte. It holds a justification flag, a 3-bit input selector and a 4-bit clock divider value. From the divider value the block produces a single-cycle enable pulse, which paces the converter.

A start strobe freezes the selected input for the converter and marks the block busy. When the converter signals done, the block keeps the 10-bit result, drops busy and raises a sticky completion flag. The result is read back as an upper byte and a lower byte. The formatting is applied when the bytes are read, so flipping the justification flag changes how a stored result is presented.

Top module: `adc_ctl_front`

## Requirements
- R1: After reset, the control byte (address 0), upper result byte (address 1) and lower result byte (address 2) all read 00h, and `conv_busy`, `conv_complete` and `conv_chan` are 0.
- R2: A write with `reg_wr` high at address 0 stores all eight bits of `reg_wdata`, and address 0 reads them back. The control byte layout is: bit 7 is the justification flag, bits 6..4 are the input selector (binary, code k selects input k), and bits 3..0 are the divider value N.
- R3: `conv_tick` pulses for one cycle every N+1 cycles. Any control write reloads the divider. The first pulse after a write comes in the (N+1)th cycle after the write edge, so N=0 pulses every cycle and N=15 pulses every 16 cycles.
- R4: `conv_start` copies the selector into `conv_chan`. Writes to the control byte while busy leave `conv_chan` unchanged. A write in the same cycle as a start gives the start the selector value held before that write.
- R5: `conv_start` sets `conv_busy` and clears `conv_complete`. `conv_done` while busy stores `conv_result`, clears `conv_busy` and sets `conv_complete`, which stays set until the next start.
- R6: `conv_done` while not busy has no effect: the result bytes and the flags keep their values.
- R7: With the justification flag at 0, the upper byte holds result bits 9..2 in positions 7..0.
- R8: With the justification flag at 1, the upper byte holds result bit 9 in position 1 and bit 8 in position 0, and positions 7..2 are zero.
- R9: The lower byte complements the upper byte. With the flag at 0 it holds result bits 1..0 in positions 7..6 and zeros below. With the flag at 1 it holds result bits 7..0.
- R10: Changing the justification flag after a conversion reformats the stored result on the next read, with no new conversion.
- R11: Address 3 reads 00h. Writes to addresses 1, 2 and 3 change neither the control byte nor the result bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 upper, 2 lower, 3 spare) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| conv_start | input | 1 | Conversion start strobe |
| conv_tick | output | 1 | Converter clock enable pulse |
| conv_chan | output | 3 | Input selected for the running conversion |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| conv_complete | output | 1 | Sticky conversion-complete flag |

## Verification
The hardest cases to reach are the two overlaps: a control write landing in the same cycle as a start, and writes while busy that must not leak into the input being converted. The bench reaches them by driving `reg_wr` and `conv_start` on the same edge, and by rewriting the selector between start and done. It then reads `conv_chan` back at the ports. A stray done outside a conversion is injected with a result that differs from the stored one, so any leak would show in both byte reads. The divider reload is exercised by writing a new N and timing the first pulse after the write edge.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int RES_W   = 10;
  localparam int CHAN_W  = 3;
  localparam int PRESC_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_UPPER = 2'd1,
    ADDR_LOWER = 2'd2,
    ADDR_SPARE = 2'd3
  } reg_addr_e;

  // control byte layout: [7] justify, [6:4] selector, [3:0] divider
  typedef struct packed {
    logic               right_just;
    logic [CHAN_W-1:0]  chan;
    logic [PRESC_W-1:0] presc;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] fmt_upper(input logic [RES_W-1:0] res,
                                                  input logic right_just);
    logic [DATA_W-1:0] v;
    if (right_just) v = {{(DATA_W-2){1'b0}}, res[RES_W-1 -: 2]};
    else            v = res[RES_W-1 -: DATA_W];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] fmt_lower(input logic [RES_W-1:0] res,
                                                  input logic right_just);
    logic [DATA_W-1:0] v;
    if (right_just) v = res[DATA_W-1:0];
    else            v = {res[1:0], {(DATA_W-2){1'b0}}};
    return v;
  endfunction

endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              ctrl_wr_o,
  output ctrl_t             ctrl_next_o
);

  ctrl_t ctrl_q;

  assign ctrl_wr_o   = wr_i && (addr_i == ADDR_CTRL);
  assign ctrl_next_o = ctrl_t'(wdata_i);

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_wr_o) ctrl_q <= ctrl_next_o;
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADDR_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/adc_ctl_prescaler.sv
module adc_ctl_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] n_cur_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == '0);
  assign tick_o = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wrap)   cnt_q <= n_cur_i;
    else             cnt_q <= cnt_q - 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_cur_i);

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !load_i && n_cur_i != '0) |=> !tick_o);

endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic [CHAN_W-1:0] chan_sel_i,
  output logic              busy_o,
  output logic              complete_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [RES_W-1:0]  res_o
);

  logic              busy_q, complete_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  res_q;
  logic              accept_done;
  logic              stray_done;

  assign accept_done = done_i && busy_q;
  assign stray_done  = done_i && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      complete_q <= 1'b0;
      chan_q     <= '0;
      res_q      <= '0;
    end else begin
      if (accept_done) begin
        res_q      <= result_i;
        busy_q     <= 1'b0;
        complete_q <= 1'b1;
      end
      if (start_i) begin
        chan_q     <= chan_sel_i;
        busy_q     <= 1'b1;
        complete_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign complete_o = complete_q;
  assign chan_o     = chan_q;
  assign res_o      = res_q;

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o && !complete_o);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_done && !start_i) |=> !busy_o && complete_o);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, complete_o}));

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(chan_o));

  p_stray_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stray_done && !start_i) |=> $stable(res_o) && !busy_o);

endmodule

// File: rtl/adc_ctl_readmux.sv
module adc_ctl_readmux
  import adc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] upper_b, lower_b;

  assign upper_b = fmt_upper(res_i, ctrl_i.right_just);
  assign lower_b = fmt_lower(res_i, ctrl_i.right_just);

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL:  rdata_o = ctrl_i;
      ADDR_UPPER: rdata_o = upper_b;
      ADDR_LOWER: rdata_o = lower_b;
      default:    rdata_o = '0;
    endcase
  end

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.right_just && addr_i == ADDR_UPPER) |-> rdata_o[DATA_W-1:2] == '0);

  p_lower_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.right_just && addr_i == ADDR_LOWER) |-> rdata_o[DATA_W-3:0] == '0);

  p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_SPARE) |-> rdata_o == '0);

endmodule

// File: rtl/adc_ctl_front.sv
module adc_ctl_front
  import adc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              conv_start,
  output logic              conv_tick,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_complete
);

  ctrl_t             ctrl;
  ctrl_t             ctrl_next;
  logic              ctrl_wr;
  logic [RES_W-1:0]  res;

  adc_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .ctrl_o     (ctrl),
    .ctrl_wr_o  (ctrl_wr),
    .ctrl_next_o(ctrl_next)
  );

  adc_ctl_prescaler #(.W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .n_cur_i   (ctrl.presc),
    .load_i    (ctrl_wr),
    .load_val_i(ctrl_next.presc),
    .tick_o    (conv_tick)
  );

  adc_ctl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (conv_start),
    .done_i    (conv_done),
    .result_i  (conv_result),
    .chan_sel_i(ctrl.chan),
    .busy_o    (conv_busy),
    .complete_o(conv_complete),
    .chan_o    (conv_chan),
    .res_o     (res)
  );

  adc_ctl_readmux u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (reg_addr),
    .ctrl_i (ctrl),
    .res_i  (res),
    .rdata_o(reg_rdata)
  );

endmodule

// File: tb/adc_ctl_front_test.sv
module adc_ctl_front_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       conv_start = 1'b0;
  logic       conv_tick;
  logic [2:0] conv_chan;
  logic       conv_busy;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = 10'd0;
  logic       conv_complete;

  int n_checks = 0;
  int n_fail   = 0;
  logic rd_req = 1'b0;
  bit   finished = 1'b0;

  typedef struct {
    logic [1:0] addr;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctl_front uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_tick(conv_tick), .conv_chan(conv_chan), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .conv_complete(conv_complete)
  );

  // bench-side restatement of the justification rules
  function automatic logic [7:0] want_hi(logic [9:0] r, logic rj);
    logic [7:0] v = 8'h00;
    if (rj) begin v[1] = r[9]; v[0] = r[8]; end
    else for (int i = 0; i < 8; i++) v[i] = r[i+2];
    return v;
  endfunction

  function automatic logic [7:0] want_lo(logic [9:0] r, logic rj);
    logic [7:0] v = 8'h00;
    if (rj) for (int i = 0; i < 8; i++) v[i] = r[i];
    else begin v[7] = r[1]; v[6] = r[0]; end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares
  always @(negedge clk) begin
    if (rd_req) begin
      sb_item_t it;
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: actual empty expected item");
      end else begin
        it = sb_q.pop_front();
        check(it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic expect_read(logic [1:0] a, logic [7:0] e, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    sb_q.push_back('{addr: a, exp: e, tag: tag});
    rd_req = 1'b1;
    @(negedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; conv_start = 1'b1;
    @(posedge clk); #1; conv_start = 1'b0;
  endtask

  task automatic pulse_done(logic [9:0] v);
    @(posedge clk); #1; conv_done = 1'b1; conv_result = v;
    @(posedge clk); #1; conv_done = 1'b0; conv_result = 10'h3FF;
  endtask

  task automatic run_conv(logic [9:0] v);
    pulse_start();
    repeat (3) @(posedge clk);
    pulse_done(v);
  endtask

  // after a control write, time the divider pulses
  task automatic tick_probe(logic [7:0] ctrl, int win, string tag);
    int n = ctrl[3:0];
    int first = -1;
    int cnt = 0;
    reg_write(2'd0, ctrl);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (conv_tick) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    check({tag, " first pulse index"}, first, n);
    check({tag, " pulse count"}, cnt, win / (n + 1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] ra, rb;
    ra = 10'h2D6;
    rb = 10'h155;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 busy", conv_busy, 0);
    check("R1 complete", conv_complete, 0);
    check("R1 chan", conv_chan, 0);
    expect_read(2'd0, 8'h00, "R1 ctrl");
    expect_read(2'd1, 8'h00, "R1 upper");
    expect_read(2'd2, 8'h00, "R1 lower");

    // R2 control read/write
    reg_write(2'd0, 8'hA5);
    expect_read(2'd0, 8'hA5, "R2 ctrl readback");
    reg_write(2'd0, 8'h5A);
    expect_read(2'd0, 8'h5A, "R2 ctrl readback 2");

    // R3 divider
    tick_probe(8'h03, 16, "R3 N=3");
    tick_probe(8'h00, 16, "R3 N=0");
    tick_probe(8'h0F, 32, "R3 N=15");
    tick_probe(8'h06, 28, "R3 N=6 reload");

    // R4/R5 conversion on input 5
    reg_write(2'd0, 8'h50);
    pulse_start();
    @(negedge clk);
    check("R5 busy after start", conv_busy, 1);
    check("R5 complete cleared", conv_complete, 0);
    check("R4 chan captured", conv_chan, 5);
    reg_write(2'd0, 8'h20);
    @(negedge clk);
    check("R4 chan held while busy", conv_chan, 5);
    pulse_done(ra);
    @(negedge clk);
    check("R5 busy cleared", conv_busy, 0);
    check("R5 complete set", conv_complete, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 complete sticky", conv_complete, 1);

    // R7 / R9 left justified
    expect_read(2'd1, want_hi(ra, 1'b0), "R7 upper left");
    expect_read(2'd2, want_lo(ra, 1'b0), "R9 lower left");

    // R10 / R8 reformat same result
    reg_write(2'd0, 8'hA0);
    expect_read(2'd1, want_hi(ra, 1'b1), "R8 upper right");
    expect_read(2'd2, want_lo(ra, 1'b1), "R9 lower right");
    expect_read(2'd1, 8'h02, "R10 reformatted upper");
    reg_write(2'd0, 8'h20);
    expect_read(2'd1, 8'hB5, "R10 back to left upper");

    // R6 stray done
    pulse_done(10'h0FF);
    @(negedge clk);
    check("R6 busy stays low", conv_busy, 0);
    check("R6 complete kept", conv_complete, 1);
    expect_read(2'd1, want_hi(ra, 1'b0), "R6 upper unchanged");
    expect_read(2'd2, want_lo(ra, 1'b0), "R6 lower unchanged");

    // R4 write and start on the same edge
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hE0; conv_start = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; conv_start = 1'b0;
    @(negedge clk);
    check("R4 same-cycle start uses old selector", conv_chan, 2);
    expect_read(2'd0, 8'hE0, "R2 ctrl after same-cycle write");
    repeat (2) @(posedge clk);
    pulse_done(rb);
    expect_read(2'd1, want_hi(rb, 1'b1), "R8 second result upper");
    expect_read(2'd2, want_lo(rb, 1'b1), "R9 second result lower");

    // new start clears complete
    run_conv(10'h3C1);
    expect_read(2'd1, want_hi(10'h3C1, 1'b1), "R8 third result upper");

    // R11 spare address and ignored writes
    reg_write(2'd1, 8'hFF);
    reg_write(2'd2, 8'hFF);
    reg_write(2'd3, 8'hFF);
    expect_read(2'd0, 8'hE0, "R11 ctrl unchanged");
    expect_read(2'd1, want_hi(10'h3C1, 1'b1), "R11 upper unchanged");
    expect_read(2'd2, want_lo(10'h3C1, 1'b1), "R11 lower unchanged");
    expect_read(2'd3, 8'h00, "R11 spare reads zero");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule